// File: doc/BRIEF.md
# Bus Hold Arbiter with Refresh Reclaim

This block decides when an external bus master may borrow the local bus and when the bus is handed back. An asynchronous hold request is synchronized, then granted only at a point where no transfer is split. Once the request is granted, the acknowledge output rises and the pad float enable rises with it. When the request is withdrawn, the acknowledge falls. The pads stay floated until the local bus unit actually needs the bus again.

In enhanced mode, a refresh that becomes due while the external master owns the bus makes the block drop its acknowledge early. This asks the master to let go. The block keeps the pads floated until the request is withdrawn, and the refresh then gets the first use of the bus. With enhanced mode off, a pending refresh has no effect while the bus is lent out.

Top module: `bus_hold_arb`

## Requirements
- R1: While reset is active, and after it has been released, until a request is granted: `hold_ack`=0, `pad_float`=0 and `local_grant`=1. Reset is asynchronous on assertion and is released through two flops.
- R2: `hold_req` passes through two synchronizer flops. When the bus is idle, `hold_ack` rises on the third rising clock edge after `hold_req` goes high, and not earlier.
- R3: While `cyc_busy`=1 and `cyc_last`=0, a request is never granted. It is granted on the edge where `cyc_last`=1, or where `cyc_busy`=0.
- R4: `pad_float` and `hold_ack` rise on the same edge, and `local_grant` falls on that edge.
- R5: While the bus is lent out, a synchronized request that is seen low makes `hold_ack` fall on the next edge, with `pad_float` still 1 and `local_grant` still 0.
- R6: After the handback, `pad_float` stays 1 until `local_req`=1 or `rfsh_due`=1. One edge later, `local_grant`=1 and `pad_float`=0.
- R7: With `enh_mode`=1, `rfsh_due`=1 while the bus is lent out makes `hold_ack` fall on the next edge, with `pad_float` kept at 1.
- R8: After such a reclaim, the pads stay floated and `hold_ack` stays 0 until the synchronized request is low.
- R9: With `enh_mode`=0, `rfsh_due` has no effect while the bus is lent out. `hold_ack` stays 1.
- R10: When the bus is taken back while a refresh is due, a new request is not granted until `rfsh_due` falls.
- R11: During the handback wait with no local demand, a fresh request is granted again directly: `hold_ack` rises and `local_grant` stays 0.
- R12: `hold_ack`=1 always implies `pad_float`=1, and `hold_ack` and `local_grant` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | Asynchronous bus request from the external master, active high |
| enh_mode | input | 1 | Enables early acknowledge drop for a pending refresh |
| cyc_busy | input | 1 | The bus unit is inside a transfer |
| cyc_last | input | 1 | The current clock is the last of the transfer |
| local_req | input | 1 | The bus unit needs to run a bus cycle |
| rfsh_due | input | 1 | A memory refresh is pending |
| hold_ack | output | 1 | Acknowledge to the external master |
| pad_float | output | 1 | Float enable for address, data and control drivers |
| local_grant | output | 1 | The local bus unit owns the bus |

## Verification
The bench times the acknowledge to the exact edge after a request. A design with one synchronizer flop too few or too many would acknowledge a cycle early or late. It holds a request through a long transfer, where a design that ignores transfer boundaries would float the pads mid-cycle. It drives a refresh into a lent bus with enhanced mode on and off: a wrong design would either never reclaim, or reclaim when it should not and lower the acknowledge. It checks that the pads stay floated after the handback, and that a refresh is served before a new request. A design that restores the pads at once, or re-grants ahead of the refresh, would show the wrong outputs there.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;
  typedef enum logic [1:0] {
    ST_OWNED   = 2'd0,
    ST_LENT    = 2'd1,
    ST_RECLAIM = 2'd2,
    ST_HANDBACK = 2'd3
  } arb_state_e;
endpackage

// File: rtl/hold_arb_sync.sv
module hold_arb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rst_int_n,
  output logic sync_out
);
  localparam int LAST = STAGES - 1;

  logic [1:0]      rst_q;
  logic [LAST:0]   chain_q;
  logic [LAST:0]   chain_d;

  // Reset: asserted asynchronously, released after two edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = async_in;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) chain_q[i] <= 1'b0;
        else            chain_q[i] <= chain_d[i];
      end
    end
  endgenerate

  assign sync_out = chain_q[LAST];
endmodule

// File: rtl/hold_arb_fsm.sv
module hold_arb_fsm
  import hold_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_s,
  input  logic       enh_mode,
  input  logic       cyc_busy,
  input  logic       cyc_last,
  input  logic       local_req,
  input  logic       rfsh_due,
  output arb_state_e state
);
  arb_state_e state_d;
  logic       owed_q, owed_d, owed_en;
  logic       at_boundary;
  logic       rfsh_block;

  assign at_boundary = !cyc_busy || cyc_last;
  assign rfsh_block  = owed_q && rfsh_due;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_OWNED: begin
        if (hold_s && at_boundary && !rfsh_block) state_d = ST_LENT;
      end
      ST_LENT: begin
        if (!hold_s)                   state_d = ST_HANDBACK;
        else if (enh_mode && rfsh_due) state_d = ST_RECLAIM;
      end
      ST_RECLAIM: begin
        if (!hold_s) state_d = ST_HANDBACK;
      end
      ST_HANDBACK: begin
        if (rfsh_due)       state_d = ST_OWNED;
        else if (hold_s)    state_d = ST_LENT;
        else if (local_req) state_d = ST_OWNED;
      end
      default: state_d = ST_OWNED;
    endcase
  end

  // Refresh-first marker: set when the bus returns for a refresh.
  always_comb begin
    owed_en = 1'b0;
    owed_d  = owed_q;
    if (state == ST_HANDBACK && rfsh_due) begin
      owed_en = 1'b1;
      owed_d  = 1'b1;
    end else if (!rfsh_due) begin
      owed_en = 1'b1;
      owed_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OWNED;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       owed_q <= 1'b0;
    else if (owed_en) owed_q <= owed_d;
  end

  p_no_midcycle_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OWNED && cyc_busy && !cyc_last) |=> (state != ST_LENT));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LENT && !hold_s) |=> (state == ST_HANDBACK));

  p_reclaim_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LENT && hold_s && enh_mode && rfsh_due) |=> (state == ST_RECLAIM));

  p_reclaim_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECLAIM && hold_s) |=> (state == ST_RECLAIM));

  p_plain_ignores_rfsh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LENT && hold_s && !enh_mode) |=> (state == ST_LENT));

  p_rfsh_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HANDBACK && rfsh_due) |=> (state == ST_OWNED));
endmodule

// File: rtl/hold_arb_outdec.sv
module hold_arb_outdec
  import hold_arb_pkg::*;
(
  input  arb_state_e state,
  output logic       hold_ack,
  output logic       pad_float,
  output logic       local_grant
);
  always_comb begin
    hold_ack    = 1'b0;
    pad_float   = 1'b0;
    local_grant = 1'b0;
    unique case (state)
      ST_OWNED:    local_grant = 1'b1;
      ST_LENT:     begin hold_ack = 1'b1; pad_float = 1'b1; end
      ST_RECLAIM:  pad_float = 1'b1;
      ST_HANDBACK: pad_float = 1'b1;
      default:     local_grant = 1'b1;
    endcase
  end
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
  import hold_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic enh_mode,
  input  logic cyc_busy,
  input  logic cyc_last,
  input  logic local_req,
  input  logic rfsh_due,
  output logic hold_ack,
  output logic pad_float,
  output logic local_grant
);
  logic       rst_int_n;
  logic       hold_s;
  arb_state_e state;

  hold_arb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(hold_req),
    .rst_int_n(rst_int_n), .sync_out(hold_s)
  );

  hold_arb_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .hold_s(hold_s), .enh_mode(enh_mode),
    .cyc_busy(cyc_busy), .cyc_last(cyc_last), .local_req(local_req),
    .rfsh_due(rfsh_due), .state(state)
  );

  hold_arb_outdec u_dec (
    .state(state), .hold_ack(hold_ack), .pad_float(pad_float),
    .local_grant(local_grant)
  );

  p_ack_floats_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    hold_ack |-> (pad_float && !local_grant));

  p_float_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (local_grant && $past(local_grant) == 1'b1 && !$past(pad_float)) |-> !pad_float);
endmodule

// File: tb/sim_bus_hold_arb.sv
`timescale 1ns/1ps
module sim_bus_hold_arb;
  logic clk = 1'b0;
  logic rst_n, hold_req, enh_mode, cyc_busy, cyc_last, local_req, rfsh_due;
  logic hold_ack, pad_float, local_grant;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;

  bus_hold_arb u0 (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .enh_mode(enh_mode),
    .cyc_busy(cyc_busy), .cyc_last(cyc_last), .local_req(local_req),
    .rfsh_due(rfsh_due), .hold_ack(hold_ack), .pad_float(pad_float),
    .local_grant(local_grant)
  );

  // Reference model built from the requirements (0 owned, 1 lent, 2 reclaim, 3 handback)
  logic [1:0] m_rq, m_sy, m_st;
  logic       m_owed;

  function automatic logic [1:0] f_next(input logic [1:0] st, input logic hs,
      input logic en, input logic cb, input logic cl, input logic lr,
      input logic rd, input logic ow);
    case (st)
      2'd0: return (hs && (!cb || cl) && !(ow && rd)) ? 2'd1 : 2'd0;
      2'd1: return !hs ? 2'd3 : ((en && rd) ? 2'd2 : 2'd1);
      2'd2: return !hs ? 2'd3 : 2'd2;
      default: return rd ? 2'd0 : (hs ? 2'd1 : (lr ? 2'd0 : 2'd3));
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rq <= 2'b00; m_sy <= 2'b00; m_st <= 2'd0; m_owed <= 1'b0;
    end else begin
      m_rq <= {m_rq[0], 1'b1};
      if (!m_rq[1]) begin
        m_sy <= 2'b00; m_st <= 2'd0; m_owed <= 1'b0;
      end else begin
        m_sy <= {m_sy[0], hold_req};
        m_st <= f_next(m_st, m_sy[1], enh_mode, cyc_busy, cyc_last, local_req, rfsh_due, m_owed);
        if (m_st == 2'd3 && rfsh_due) m_owed <= 1'b1;
        else if (!rfsh_due)           m_owed <= 1'b0;
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic outs(input logic a, input logic f, input logic g, input string tag);
    chk(hold_ack, a, {tag, " hold_ack"});
    chk(pad_float, f, {tag, " pad_float"});
    chk(local_grant, g, {tag, " local_grant"});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hold_req = 1'b0; enh_mode = 1'b1; cyc_busy = 1'b0;
    cyc_last = 1'b0; local_req = 1'b0; rfsh_due = 1'b0;
    step(1);
    outs(1'b0, 1'b0, 1'b1, "R1 in reset");
    step(2); rst_n = 1'b1; step(3);
    outs(1'b0, 1'b0, 1'b1, "R1 after reset");

    // R2: exact grant latency
    hold_req = 1'b1;
    step(2); chk(hold_ack, 1'b0, "R2 not before third edge");
    step(1); outs(1'b1, 1'b1, 1'b0, "R2 third edge");

    // R7/R8 reclaim in enhanced mode
    rfsh_due = 1'b1;
    step(1); outs(1'b0, 1'b1, 1'b0, "R7 reclaim");
    step(4); outs(1'b0, 1'b1, 1'b0, "R8 waits for release");
    hold_req = 1'b0;
    step(3); outs(1'b0, 1'b1, 1'b0, "R8 handback");
    step(1); outs(1'b0, 1'b0, 1'b1, "R6 refresh takes bus");

    // R10 refresh first
    hold_req = 1'b1;
    step(6); outs(1'b0, 1'b0, 1'b1, "R10 request held off");
    rfsh_due = 1'b0;
    step(1); outs(1'b1, 1'b1, 1'b0, "R10 granted after refresh");

    // R9 plain mode ignores refresh
    enh_mode = 1'b0; rfsh_due = 1'b1;
    step(4); outs(1'b1, 1'b1, 1'b0, "R9 no reclaim");
    rfsh_due = 1'b0; enh_mode = 1'b1;

    // R5/R6 release and floating wait
    hold_req = 1'b0;
    step(3); outs(1'b0, 1'b1, 1'b0, "R5 release");
    step(4); outs(1'b0, 1'b1, 1'b0, "R6 pads stay floated");

    // R11 regrant from handback
    hold_req = 1'b1;
    step(2); chk(hold_ack, 1'b0, "R11 before sync");
    step(1); outs(1'b1, 1'b1, 1'b0, "R11 direct regrant");
    hold_req = 1'b0;
    step(3); outs(1'b0, 1'b1, 1'b0, "R5 second release");
    local_req = 1'b1;
    step(1); outs(1'b0, 1'b0, 1'b1, "R6 local demand");
    local_req = 1'b0;

    // R3/R4 no grant inside a transfer
    cyc_busy = 1'b1; cyc_last = 1'b0; hold_req = 1'b1;
    step(6); outs(1'b0, 1'b0, 1'b1, "R3 mid transfer");
    cyc_last = 1'b1;
    step(1); outs(1'b1, 1'b1, 1'b0, "R4 same-edge float");
    cyc_busy = 1'b0; cyc_last = 1'b0; hold_req = 1'b0;
    step(4);

    // Random phase against the model (R12 every cycle)
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      chk(hold_ack, (m_st == 2'd1), "R12 model hold_ack");
      chk(pad_float, (m_st != 2'd0), "R12 model pad_float");
      chk(local_grant, (m_st == 2'd0), "R12 model local_grant");
      if (hold_ack && local_grant) chk(1'b1, 1'b0, "R12 exclusive");
      if (($urandom % 8) == 0)  hold_req = ~hold_req;
      if (($urandom % 16) == 0) rfsh_due = ~rfsh_due;
      if (($urandom % 64) == 0) enh_mode = ~enh_mode;
      cyc_busy  = ($urandom % 3) != 0;
      cyc_last  = ($urandom % 4) == 0;
      local_req = ($urandom % 4) == 0;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule